// File: doc/BRIEF.md
# Mirrored Johnson LED Flow Sequencer

This block drives an 8-bit LED vector with a light pattern that moves in from both outer edges toward the middle and then drains back out, over and over. A four-stage twisted-ring shift register, whose first stage takes the inverted value of its last stage, produces the pattern. Each stage lights a symmetric pair of LEDs, so the ring's fill-and-empty motion appears as a flow toward the centre.

The ring must step slowly enough for the eye to follow. A free-running prescaler made of two cascaded counters divides the system clock. One selectable bit of the upper counter sets the step rate. A rising edge on that bit makes a one-cycle enable pulse, so the whole design runs in a single clock domain. The reset input is active low. Inside the block it is inverted into a synchronous clear for the prescaler, the ring and the output register.

Top module: `led_flow_seq`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `led` is 8'h00 from that edge on.
- R2: The lower prescaler counter counts up by one on every clock and wraps. The upper counter advances only in a cycle where the lower counter holds its all-ones value.
- R3: The ring advances only on a one-cycle step pulse. That pulse fires when upper-counter bit `TAP` changes from 0 to 1, and two pulses never occur in back-to-back cycles.
- R4: In steady running, `led` changes once every 2^(LO_W+TAP+1) clocks.
- R5: After `rst_n` is released, the first change of `led` appears 2^(LO_W+TAP)+2 rising edges later, counting the first edge that samples `rst_n` high as edge 1.
- R6: The ring visits exactly eight states in this order and repeats: 0000, 0001, 0011, 0111, 1111, 1110, 1100, 1000. On each step the new bit 0 equals the inverse of the old bit 3, and bits 3..1 take the old bits 2..0.
- R7: Stage k drives both `led[k]` and `led[7-k]`, so `led[i]` always equals `led[7-i]`. The output codes for the eight states, in order, are 00, 81, C3, E7, FF, 7E, 3C, 18 (hex).
- R8: `led` is registered and follows the ring state one clock later.
- R9: A reset in the middle of a run turns all LEDs off. After release, the pattern starts again from 00 with the same first-step latency as after power-up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (nominally 50 MHz) |
| rst_n | input | 1 | Active-low reset, sampled synchronously |
| led | output | 8 | Mirrored LED pattern, registered |

## Verification
The bench builds the block with a 2-bit lower counter, a 4-bit upper counter and tap bit 1. This makes one ring step take 16 clocks instead of about 2^24. Within a few hundred cycles the bench can walk two full laps of the eight-state pattern, measure each step interval exactly, and measure the exact latency from reset release to the first step. The same short period lets a reset land mid-run and lets the bench confirm that timing restarts from zero.

// File: rtl/led_flow_pkg.sv
package led_flow_pkg;
  // Default sizes: 16-bit counters, tap in the middle of the upper counter.
  localparam int DEF_LO_W   = 16;
  localparam int DEF_HI_W   = 16;
  localparam int DEF_TAP    = 7;
  localparam int DEF_STAGES = 4;

  // Number of distinct states a twisted ring of n stages passes through.
  function automatic int ring_lap_len(input int n);
    return 2 * n;
  endfunction
endpackage

// File: rtl/lf_prescaler.sv
module lf_prescaler #(
  parameter int LO_W = 16,
  parameter int HI_W = 16,
  parameter int TAP  = 7
) (
  input  logic clk,
  input  logic clr,
  output logic tap_o
);
  logic [LO_W-1:0] lo_cnt;
  logic [HI_W-1:0] hi_cnt;
  logic            lo_wrap;

  assign lo_wrap = (lo_cnt == {LO_W{1'b1}});

  // Lower stage: count enable tied active, free running.
  always_ff @(posedge clk) begin
    if (clr) lo_cnt <= '0;
    else     lo_cnt <= lo_cnt + 1'b1;
  end

  // Upper stage advances once per full cycle of the lower stage's top bit.
  always_ff @(posedge clk) begin
    if (clr)          hi_cnt <= '0;
    else if (lo_wrap) hi_cnt <= hi_cnt + 1'b1;
  end

  assign tap_o = hi_cnt[TAP];

  // R2: lower counter steps by one each clock
  a_r2_lo_increments: assert property (@(posedge clk) disable iff (clr)
    1'b1 |=> (lo_cnt == $past(lo_cnt) + 1'b1));
  // R2: upper counter holds unless the lower one wrapped
  a_r2_hi_holds: assert property (@(posedge clk) disable iff (clr)
    (lo_cnt != {LO_W{1'b1}}) |=> $stable(hi_cnt));
endmodule

// File: rtl/lf_tap_edge.sv
module lf_tap_edge (
  input  logic clk,
  input  logic clr,
  input  logic tap_i,
  output logic step_o
);
  logic tap_q;

  always_ff @(posedge clk) begin
    if (clr) tap_q <= 1'b0;
    else     tap_q <= tap_i;
  end

  assign step_o = tap_i & ~tap_q;

  // R3: step is a single-cycle pulse
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (clr)
    step_o |=> !step_o);
endmodule

// File: rtl/lf_johnson_ring.sv
module lf_johnson_ring #(
  parameter int STAGES = 4
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              step,
  output logic [STAGES-1:0] ring_o
);
  logic [STAGES-1:0] ring_q;

  always_ff @(posedge clk) begin
    if (clr)       ring_q <= '0;
    else if (step) ring_q <= {ring_q[STAGES-2:0], ~ring_q[STAGES-1]};
  end

  assign ring_o = ring_q;

  // R3: no movement without a step pulse
  a_r3_ring_holds: assert property (@(posedge clk) disable iff (clr)
    !step |=> $stable(ring_q));
  // R6: inverted feedback into stage 0
  a_r6_feedback: assert property (@(posedge clk) disable iff (clr)
    step |=> (ring_q[0] == !$past(ring_q[STAGES-1])));
  // R6: remaining stages shift up by one
  a_r6_shift: assert property (@(posedge clk) disable iff (clr)
    step |=> (ring_q[STAGES-1:1] == $past(ring_q[STAGES-2:0])));
endmodule

// File: rtl/lf_mirror_out.sv
module lf_mirror_out #(
  parameter int STAGES = 4,
  localparam int LED_W = 2 * STAGES
) (
  input  logic              clk,
  input  logic              clr,
  input  logic [STAGES-1:0] ring_i,
  output logic [LED_W-1:0]  led_o
);
  logic [LED_W-1:0] led_d;

  for (genvar k = 0; k < STAGES; k++) begin : g_pair
    assign led_d[k]           = ring_i[k];
    assign led_d[LED_W-1-k]   = ring_i[k];
  end

  always_ff @(posedge clk) begin
    if (clr) led_o <= '0;
    else     led_o <= led_d;
  end

  // R8: output follows the ring one clock later (low half)
  a_r8_registered: assert property (@(posedge clk) disable iff (clr)
    1'b1 |=> (led_o[STAGES-1:0] == $past(ring_i)));
endmodule

// File: rtl/led_flow_seq.sv
module led_flow_seq
  import led_flow_pkg::*;
#(
  parameter int LO_W   = DEF_LO_W,
  parameter int HI_W   = DEF_HI_W,
  parameter int TAP    = DEF_TAP,
  parameter int STAGES = DEF_STAGES,
  localparam int LED_W = 2 * STAGES
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [LED_W-1:0] led
);
  logic              clr;
  logic              tap;
  logic              step;
  logic [STAGES-1:0] ring;

  assign clr = ~rst_n;

  lf_prescaler #(.LO_W(LO_W), .HI_W(HI_W), .TAP(TAP)) u_presc (
    .clk(clk), .clr(clr), .tap_o(tap));

  lf_tap_edge u_edge (
    .clk(clk), .clr(clr), .tap_i(tap), .step_o(step));

  lf_johnson_ring #(.STAGES(STAGES)) u_ring (
    .clk(clk), .clr(clr), .step(step), .ring_o(ring));

  lf_mirror_out #(.STAGES(STAGES)) u_out (
    .clk(clk), .clr(clr), .ring_i(ring), .led_o(led));

  // R1: reset sampled low blanks the LEDs
  a_r1_reset_blank: assert property (@(posedge clk)
    clr |=> (led == '0));
  // R7: symmetric pairs, checked one cycle after reset has left
  a_r7_mirror: assert property (@(posedge clk) disable iff (clr)
    1'b1 |=> (led[STAGES-1:0] == {<<{led[LED_W-1:STAGES]}}));
endmodule

// File: tb/test_led_flow_seq.sv
module test_led_flow_seq;
  localparam int LO_W = 2;
  localparam int HI_W = 4;
  localparam int TAP  = 1;
  localparam int STEP_IVL  = 1 << (LO_W + TAP + 1);
  localparam int FIRST_LAT = (1 << (LO_W + TAP)) + 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] led;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  led_flow_seq #(.LO_W(LO_W), .HI_W(HI_W), .TAP(TAP), .STAGES(4)) i_led_flow_seq (
    .clk(clk), .rst_n(rst_n), .led(led));

  always #5 clk = ~clk;

  function automatic logic [7:0] code_at(input int idx);
    case (idx % 8)
      0: return 8'h00;
      1: return 8'h81;
      2: return 8'hC3;
      3: return 8'hE7;
      4: return 8'hFF;
      5: return 8'h7E;
      6: return 8'h3C;
      default: return 8'h18;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Count edges until led differs from its current value (sampled at negedge).
  task automatic wait_change(output int n);
    logic [7:0] prev;
    prev = led;
    n = 0;
    do begin
      @(posedge clk);
      @(negedge clk);
      n++;
    end while (led == prev && n < 4 * STEP_IVL);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(led == 8'h00, "R1 reset blank", led, 8'h00);
  endtask

  task automatic t_first_step;
    int n;
    @(negedge clk);
    rst_n = 1'b1;
    wait_change(n);
    check(n == FIRST_LAT, "R5 first-step latency", n, FIRST_LAT);
    check(led == code_at(1), "R7 first code", led, code_at(1));
  endtask

  task automatic t_two_laps;
    int n;
    for (int s = 2; s <= 17; s++) begin
      wait_change(n);
      check(n == STEP_IVL, "R4 step interval", n, STEP_IVL);
      check(led == code_at(s), "R6 sequence order", led, code_at(s));
      for (int i = 0; i < 4; i++)
        check(led[i] == led[7-i], "R7 mirror pair", led[i], led[7-i]);
    end
  endtask

  task automatic t_hold_between;
    logic [7:0] held;
    held = led;
    repeat (STEP_IVL - 2) @(negedge clk);
    check(led == held, "R3 hold between steps", led, held);
  endtask

  task automatic t_mid_reset;
    int n;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(led == 8'h00, "R9 mid-run blank", led, 8'h00);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    wait_change(n);
    check(n == FIRST_LAT, "R9 restart latency", n, FIRST_LAT);
    check(led == code_at(1), "R9 restart code", led, code_at(1));
    wait_change(n);
    check(n == STEP_IVL, "R2 prescaler period after restart", n, STEP_IVL);
    check(led == code_at(2), "R8 second code", led, code_at(2));
  endtask

  initial begin
    t_reset();
    t_first_step();
    t_two_laps();
    t_hold_between();
    t_mid_reset();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule